// File: doc/BRIEF.md
# Mains-Timed Clock and Calendar Counter

This block keeps the time of day and a calendar date, using a low-voltage pulse train taken from the mains supply as its timebase. Each rising edge of that pulse train is synchronized into the system clock domain and counted. A prescaler divides it by one of two parameterized ratios, 50 or 60 by default, chosen by a select pin, so a one-second tick results on either mains frequency. The seconds, minutes and hours run in 24-hour form. At midnight the weekday, the day of the month and the month advance.

The time and date appear as BCD digits, and the month and weekday as small numeric codes that a later stage turns into letters. No year is kept. A leap-year pin, set by hand, chooses whether February has 29 days. A synchronous load port sets the time and date. It forces any out-of-range value into its legal range. A blank output marks a programmable window of hours, so that a display stage can stay dark overnight.

Top module: `mains_clock_cal`

## Requirements
- R1: One second passes every DIV_SEL0 rising edges of `mains_in` when `rate_sel` is 0, and every DIV_SEL1 rising edges when it is 1. Each rising edge counts once, however long the pulse stays high.
- R2: Seconds and minutes each count 0..59. Seconds wrap to 0 and carry into minutes. Minutes wrap to 0 and carry into hours.
- R3: Hours count 0..23. A carry out of 23:59:59 gives 00:00:00 and advances the calendar by one day.
- R4: The weekday code is 0..6. It advances by one at each midnight and wraps from 6 back to 0.
- R5: The month code runs 1 = January to 12 = December. Months 4, 6, 9 and 11 have 30 days, month 2 is covered by R6, and every other month has 31 days. Past the last day of a month the day returns to 1 and the month advances, and month 12 is followed by month 1.
- R6: February has 29 days when `leap_year` is 1 and 28 days when it is 0.
- R7: A cycle with `load` high writes the hour, minute, weekday, day and month. It sets the seconds to 0 and clears the prescaler, so the next second ends exactly one full divide ratio later.
- R8: Loaded values are clamped. An hour above 23 becomes 23, a minute above 59 becomes 59, and a weekday above 6 becomes 6. A month of 0 becomes 1 and a month above 12 becomes 12. A day of 0 becomes 1, and a day past the length of the clamped month becomes that length.
- R9: `blank_o` is 1 when the hour h lies in the half-open window that starts at `blank_start` and stops before `blank_end`. When start is below end, the condition is start <= h < end. When start is above end, the window wraps through midnight and the condition is h >= start or h < end. When start equals end, `blank_o` stays 0.
- R10: Reset gives 00:00:00, day 1, month 1, weekday 0 and `blank_o` 0.
- R11: Outputs are registered. Each digit is plain BCD, tens and ones, for the hour, minute, second and day. The month and weekday are output in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mains_in | input | 1 | Raw mains-derived pulse, asynchronous |
| rate_sel | input | 1 | 0: divide by DIV_SEL0, 1: divide by DIV_SEL1 |
| leap_year | input | 1 | February has 29 days when 1 |
| load | input | 1 | Write the load fields this cycle |
| ld_hour | input | 5 | Hour to load, binary |
| ld_min | input | 6 | Minute to load, binary |
| ld_wday | input | 3 | Weekday code to load |
| ld_day | input | 5 | Day of month to load, binary |
| ld_month | input | 4 | Month code to load |
| blank_start | input | 5 | First blanked hour |
| blank_end | input | 5 | First hour after the blank window |
| hour_tens_o | output | 2 | Hour tens digit |
| hour_ones_o | output | 4 | Hour ones digit |
| min_tens_o | output | 3 | Minute tens digit |
| min_ones_o | output | 4 | Minute ones digit |
| sec_tens_o | output | 3 | Second tens digit |
| sec_ones_o | output | 4 | Second ones digit |
| day_tens_o | output | 2 | Day-of-month tens digit |
| day_ones_o | output | 4 | Day-of-month ones digit |
| month_o | output | 4 | Month code, 1..12 |
| wday_o | output | 3 | Weekday code, 0..6 |
| blank_o | output | 1 | Display blank request |

## Verification
Month-end rollovers are hard to reach from the ports. Counting up to them from reset would take on the order of a billion mains edges. The bench uses a small divide configuration and loads the last day of each month at 23:59. It then feeds exactly one minute of pulses, so each month boundary is reached within a few thousand cycles, including both February cases. A second case that needs care is a load that lands while the prescaler holds a partial count. The bench feeds part of a second, loads, and then counts the edges needed for the next tick.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int WDAY_W = 3;

  // Days in a month: month code 1..12, February follows the leap flag.
  function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mon, input logic leap);
    case (mon)
      4'd2:                      month_days = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_days = 5'd30;
      default:                   month_days = 5'd31;
    endcase
  endfunction

  // Binary 0..99 to two BCD nibbles {tens, ones}.
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] r;
    t = v / 7'd10;
    r = v - t * 7'd10;
    to_bcd = {t[3:0], r[3:0]};
  endfunction
endpackage

// File: rtl/mains_prescaler.sv
module mains_prescaler #(
  parameter int DIV_SEL0 = 50,
  parameter int DIV_SEL1 = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic mains_in,
  input  logic rate_sel,
  input  logic clear,
  output logic tick
);
  localparam int DIV_MAX = (DIV_SEL0 > DIV_SEL1) ? DIV_SEL0 : DIV_SEL1;
  localparam int CW      = $clog2(DIV_MAX + 1);
  localparam logic [CW-1:0] LAST0 = CW'(DIV_SEL0 - 1);
  localparam logic [CW-1:0] LAST1 = CW'(DIV_SEL1 - 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          rise;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign rise = sync_q[1] & ~prev_q;
  assign last = rate_sel ? LAST1 : LAST0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      tick   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], mains_in};
      prev_q <= sync_q[1];
      tick   <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else if (rise) begin
        if (cnt_q >= last) begin
          cnt_q <= '0;
          tick  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R1
  AST_PRESC_BOUND:   assert property (@(posedge clk) disable iff (rst) cnt_q < CW'(DIV_MAX)); // R1
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import clk_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [HOUR_W-1:0] ld_hour,
  input  logic [MIN_W-1:0]  ld_min,
  output logic [HOUR_W-1:0] hour,
  output logic [MIN_W-1:0]  min,
  output logic [MIN_W-1:0]  sec,
  output logic              day_roll
);
  assign day_roll = tick & ~load & (sec == 6'd59) & (min == 6'd59) & (hour == 5'd23);

  always_ff @(posedge clk) begin
    if (rst) begin
      hour <= '0;
      min  <= '0;
      sec  <= '0;
    end else if (load) begin
      hour <= (ld_hour > 5'd23) ? 5'd23 : ld_hour;
      min  <= (ld_min > 6'd59) ? 6'd59 : ld_min;
      sec  <= '0;
    end else if (tick) begin
      if (sec == 6'd59) begin
        sec <= '0;
        if (min == 6'd59) begin
          min  <= '0;
          hour <= (hour == 5'd23) ? 5'd0 : hour + 5'd1;
        end else begin
          min <= min + 6'd1;
        end
      end else begin
        sec <= sec + 6'd1;
      end
    end
  end

  AST_SEC_RANGE:  assert property (@(posedge clk) disable iff (rst) sec < 6'd60 && min < 6'd60); // R2
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst) hour < 5'd24); // R3
  AST_MIDNIGHT:   assert property (@(posedge clk) disable iff (rst)
                    day_roll |=> (hour == 5'd0 && min == 6'd0 && sec == 6'd0)); // R3
endmodule

// File: rtl/calendar_counter.sv
module calendar_counter
  import clk_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              leap,
  input  logic              load,
  input  logic [WDAY_W-1:0] ld_wday,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [MON_W-1:0]  ld_month,
  output logic [WDAY_W-1:0] wday,
  output logic [DAY_W-1:0]  day,
  output logic [MON_W-1:0]  month
);
  logic [DAY_W-1:0] cur_len;
  logic [MON_W-1:0] mon_c;
  logic [DAY_W-1:0] len_c;
  logic [DAY_W-1:0] day_c;

  assign cur_len = month_days(month, leap);

  always_comb begin
    if (ld_month == 4'd0)       mon_c = 4'd1;
    else if (ld_month > 4'd12)  mon_c = 4'd12;
    else                        mon_c = ld_month;
    len_c = month_days(mon_c, leap);
    if (ld_day == 5'd0)         day_c = 5'd1;
    else if (ld_day > len_c)    day_c = len_c;
    else                        day_c = ld_day;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wday  <= '0;
      day   <= 5'd1;
      month <= 4'd1;
    end else if (load) begin
      wday  <= (ld_wday > 3'd6) ? 3'd6 : ld_wday;
      day   <= day_c;
      month <= mon_c;
    end else if (advance) begin
      wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;
      if (day >= cur_len) begin
        day   <= 5'd1;
        month <= (month == 4'd12) ? 4'd1 : month + 4'd1;
      end else begin
        day <= day + 5'd1;
      end
    end
  end

  AST_DAY_LEGAL:   assert property (@(posedge clk) disable iff (rst)
                     day >= 5'd1 && day <= month_days(month, 1'b1)); // R5
  AST_MONTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
                     month >= 4'd1 && month <= 4'd12); // R5
  AST_WDAY_STEP:   assert property (@(posedge clk) disable iff (rst)
                     advance |=> wday == (($past(wday) == 3'd6) ? 3'd0 : $past(wday) + 3'd1)); // R4
endmodule

// File: rtl/mains_clock_cal.sv
module mains_clock_cal
  import clk_cal_pkg::*;
#(
  parameter int DIV_SEL0 = 50,
  parameter int DIV_SEL1 = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mains_in,
  input  logic              rate_sel,
  input  logic              leap_year,
  input  logic              load,
  input  logic [HOUR_W-1:0] ld_hour,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic [WDAY_W-1:0] ld_wday,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [MON_W-1:0]  ld_month,
  input  logic [HOUR_W-1:0] blank_start,
  input  logic [HOUR_W-1:0] blank_end,
  output logic [1:0]        hour_tens_o,
  output logic [3:0]        hour_ones_o,
  output logic [2:0]        min_tens_o,
  output logic [3:0]        min_ones_o,
  output logic [2:0]        sec_tens_o,
  output logic [3:0]        sec_ones_o,
  output logic [1:0]        day_tens_o,
  output logic [3:0]        day_ones_o,
  output logic [MON_W-1:0]  month_o,
  output logic [WDAY_W-1:0] wday_o,
  output logic              blank_o
);
  logic              tick;
  logic              day_roll;
  logic [HOUR_W-1:0] hour;
  logic [MIN_W-1:0]  min;
  logic [MIN_W-1:0]  sec;
  logic [WDAY_W-1:0] wday;
  logic [DAY_W-1:0]  day;
  logic [MON_W-1:0]  month;
  logic              in_window;
  logic [7:0]        hour_bcd, min_bcd, sec_bcd, day_bcd;

  mains_prescaler #(.DIV_SEL0(DIV_SEL0), .DIV_SEL1(DIV_SEL1)) u_presc (
    .clk(clk), .rst(rst), .mains_in(mains_in), .rate_sel(rate_sel),
    .clear(load), .tick(tick)
  );

  tod_counter u_tod (
    .clk(clk), .rst(rst), .tick(tick), .load(load),
    .ld_hour(ld_hour), .ld_min(ld_min),
    .hour(hour), .min(min), .sec(sec), .day_roll(day_roll)
  );

  calendar_counter u_cal (
    .clk(clk), .rst(rst), .advance(day_roll), .leap(leap_year), .load(load),
    .ld_wday(ld_wday), .ld_day(ld_day), .ld_month(ld_month),
    .wday(wday), .day(day), .month(month)
  );

  always_comb begin
    if (blank_start == blank_end)     in_window = 1'b0;
    else if (blank_start < blank_end) in_window = (hour >= blank_start) && (hour < blank_end);
    else                              in_window = (hour >= blank_start) || (hour < blank_end);
  end

  assign hour_bcd = to_bcd(7'(hour));
  assign min_bcd  = to_bcd(7'(min));
  assign sec_bcd  = to_bcd(7'(sec));
  assign day_bcd  = to_bcd(7'(day));

  always_ff @(posedge clk) begin
    if (rst) begin
      hour_tens_o <= '0;
      hour_ones_o <= '0;
      min_tens_o  <= '0;
      min_ones_o  <= '0;
      sec_tens_o  <= '0;
      sec_ones_o  <= '0;
      day_tens_o  <= '0;
      day_ones_o  <= 4'd1;
      month_o     <= 4'd1;
      wday_o      <= '0;
      blank_o     <= 1'b0;
    end else begin
      hour_tens_o <= hour_bcd[5:4];
      hour_ones_o <= hour_bcd[3:0];
      min_tens_o  <= min_bcd[6:4];
      min_ones_o  <= min_bcd[3:0];
      sec_tens_o  <= sec_bcd[6:4];
      sec_ones_o  <= sec_bcd[3:0];
      day_tens_o  <= day_bcd[5:4];
      day_ones_o  <= day_bcd[3:0];
      month_o     <= month;
      wday_o      <= wday;
      blank_o     <= in_window;
    end
  end

  AST_BLANK_EMPTY: assert property (@(posedge clk) disable iff (rst)
                     (blank_start == blank_end) |=> !blank_o); // R9
  AST_BCD_DIGITS:  assert property (@(posedge clk) disable iff (rst)
                     hour_tens_o <= 2'd2 && hour_ones_o <= 4'd9 && min_ones_o <= 4'd9
                     && sec_ones_o <= 4'd9 && day_ones_o <= 4'd9); // R11
endmodule

// File: tb/mains_clock_cal_tb.sv
module mains_clock_cal_tb;
  localparam int DA = 4;
  localparam int DB = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mains_in = 1'b0, rate_sel = 1'b0, leap_year = 1'b0, load = 1'b0;
  logic [4:0] ld_hour = '0, ld_day = '0, blank_start = '0, blank_end = '0;
  logic [5:0] ld_min = '0;
  logic [2:0] ld_wday = '0;
  logic [3:0] ld_month = '0;
  logic [1:0] hour_tens_o, day_tens_o;
  logic [3:0] hour_ones_o, min_ones_o, sec_ones_o, day_ones_o, month_o;
  logic [2:0] min_tens_o, sec_tens_o, wday_o;
  logic blank_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mains_clock_cal #(.DIV_SEL0(DA), .DIV_SEL1(DB)) u_dut (
    .clk(clk), .rst(rst), .mains_in(mains_in), .rate_sel(rate_sel),
    .leap_year(leap_year), .load(load), .ld_hour(ld_hour), .ld_min(ld_min),
    .ld_wday(ld_wday), .ld_day(ld_day), .ld_month(ld_month),
    .blank_start(blank_start), .blank_end(blank_end),
    .hour_tens_o(hour_tens_o), .hour_ones_o(hour_ones_o),
    .min_tens_o(min_tens_o), .min_ones_o(min_ones_o),
    .sec_tens_o(sec_tens_o), .sec_ones_o(sec_ones_o),
    .day_tens_o(day_tens_o), .day_ones_o(day_ones_o),
    .month_o(month_o), .wday_o(wday_o), .blank_o(blank_o)
  );

  function automatic logic [31:0] exp_time(input int h, input int m, input int s);
    logic [31:0] r;
    r = '0;
    r[19:0] = {2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(s / 10), 4'(s % 10)};
    return r;
  endfunction

  function automatic logic [31:0] exp_date(input int d, input int mo, input int w);
    logic [31:0] r;
    r = '0;
    r[12:0] = {2'(d / 10), 4'(d % 10), 4'(mo), 3'(w)};
    return r;
  endfunction

  function automatic int mlen(input int mo, input bit leap);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] got_time();
    logic [31:0] r;
    r = '0;
    r[19:0] = {hour_tens_o, hour_ones_o, min_tens_o, min_ones_o, sec_tens_o, sec_ones_o};
    return r;
  endfunction

  function automatic logic [31:0] got_date();
    logic [31:0] r;
    r = '0;
    r[12:0] = {day_tens_o, day_ones_o, month_o, wday_o};
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) mains_in = 1'b1;
    repeat (4) @(negedge clk);
    mains_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_load(input int h, input int m, input int w, input int d, input int mo);
    @(negedge clk);
    ld_hour = 5'(h); ld_min = 6'(m); ld_wday = 3'(w); ld_day = 5'(d); ld_month = 4'(mo);
    load = 1'b1;
    @(negedge clk) load = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 time", got_time(), exp_time(0, 0, 0));
    check("R10 date", got_date(), exp_date(1, 1, 0));
    check("R10 blank", {31'd0, blank_o}, 32'd0);

    // R1 divide ratios for both select values
    pulses(DA - 1);
    check("R1 sel0 short", got_time(), exp_time(0, 0, 0));
    pulses(1);
    check("R1 sel0 full", got_time(), exp_time(0, 0, 1));
    rate_sel = 1'b1;
    pulses(DB - 1);
    check("R1 sel1 short", got_time(), exp_time(0, 0, 1));
    pulses(1);
    check("R1 sel1 full", got_time(), exp_time(0, 0, 2));
    rate_sel = 1'b0;

    // R7 load during a partial count clears seconds and prescaler
    pulses(2);
    do_load(10, 20, 3, 15, 6);
    check("R7 time", got_time(), exp_time(10, 20, 0));
    check("R7 date", got_date(), exp_date(15, 6, 3));
    pulses(DA - 1);
    check("R7 prescaler cleared", got_time(), exp_time(10, 20, 0));
    pulses(1);
    check("R7 first second", got_time(), exp_time(10, 20, 1));

    // R2 second sweep with minute carry, R11 digits
    do_load(5, 0, 0, 1, 1);
    for (int s = 1; s <= 60; s++) begin
      pulses(DA);
      if (s < 60) check("R2 R11 seconds", got_time(), exp_time(5, 0, s));
      else        check("R2 minute carry", got_time(), exp_time(5, 1, 0));
    end
    do_load(5, 59, 0, 1, 1);
    pulses(60 * DA);
    check("R2 hour carry", got_time(), exp_time(6, 0, 0));

    // R3 midnight, R4 weekday wrap 6->0
    do_load(23, 59, 6, 10, 3);
    pulses(60 * DA);
    check("R3 midnight time", got_time(), exp_time(0, 0, 0));
    check("R3 R4 midnight date", got_date(), exp_date(11, 3, 0));

    // R5 mid-month step
    do_load(23, 59, 2, 30, 1);
    pulses(60 * DA);
    check("R5 day step", got_date(), exp_date(31, 1, 3));

    // R5 R6 last day of each month, leap clear
    for (int m = 1; m <= 12; m++) begin
      do_load(23, 59, m % 7, mlen(m, 1'b0), m);
      pulses(60 * DA);
      check("R5 R6 month end", got_date(), exp_date(1, (m == 12) ? 1 : m + 1, (m + 1) % 7));
    end

    // R6 leap February
    leap_year = 1'b1;
    do_load(23, 59, 1, 28, 2);
    pulses(60 * DA);
    check("R6 leap feb28", got_date(), exp_date(29, 2, 2));
    do_load(23, 59, 2, 29, 2);
    pulses(60 * DA);
    check("R6 leap feb29", got_date(), exp_date(1, 3, 3));
    leap_year = 1'b0;

    // R8 clamping
    do_load(31, 63, 7, 0, 0);
    check("R8 time clamp", got_time(), exp_time(23, 59, 0));
    check("R8 date low clamp", got_date(), exp_date(1, 1, 6));
    do_load(0, 0, 0, 31, 4);
    check("R8 day to 30", got_date(), exp_date(30, 4, 0));
    do_load(0, 0, 0, 30, 2);
    check("R8 feb 28", got_date(), exp_date(28, 2, 0));
    leap_year = 1'b1;
    do_load(0, 0, 0, 30, 2);
    check("R8 feb 29", got_date(), exp_date(29, 2, 0));
    leap_year = 1'b0;
    do_load(0, 0, 0, 31, 15);
    check("R8 month 12", got_date(), exp_date(31, 12, 0));

    // R9 blank windows: wrapping, plain, empty; R11 hour digits
    for (int w = 0; w < 3; w++) begin
      int bs, be;
      bs = (w == 0) ? 22 : (w == 1) ? 9 : 8;
      be = (w == 0) ? 6  : (w == 1) ? 17 : 8;
      blank_start = 5'(bs);
      blank_end   = 5'(be);
      for (int h = 0; h < 24; h++) begin
        bit e;
        do_load(h, 30, 0, 1, 1);
        if (bs == be)     e = 1'b0;
        else if (bs < be) e = (h >= bs) && (h < be);
        else              e = (h >= bs) || (h < be);
        check("R9 blank", {31'd0, blank_o}, {31'd0, e});
        check("R11 hour digits", got_time(), exp_time(h, 30, 0));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule